// File: doc/BRIEF.md
# Streaming Amplitude-Modulated Oscillator

This block is a numerically controlled oscillator that takes one 34-bit input word on every clock. Each word carries an unsigned 16-bit amplitude in its top bits and an 18-bit frequency step in its low bits. A 34-bit increment register feeds a 34-bit phase accumulator. The top 16 accumulator bits drive a pipelined CORDIC rotator, which produces a cosine and sine pair. Both outputs are then scaled by the amplitude that travelled with the word, so the frequency and the envelope can change on every cycle, as in a sweep with gain correction.

Streamed words update only the upper 18 bits of the increment register. A separate load strobe writes all 34 bits at once, which sets the 16 fine bits. Those fine bits then stay in place while streaming continues. On a strobe cycle the top input bits are increment data, so the amplitude from that word is discarded and the previous amplitude is kept. The latency is fixed, and a valid flag marks when the pipeline has filled after reset.

Top module: `nco_am_stream`

## Requirements
- R1: A synchronous, active-high `rst` clears the increment register, the accumulator, the held amplitude and the whole pipeline. While `rst` is high, at the next edge `cos_out`, `sin_out` and `out_valid` are all 0.
- R2: When `load_inc` is low, `din[33:18]` is taken as the amplitude. `din[17:0]` is written into increment register bits 33:16.
- R3: If no strobe load has happened since reset, increment register bits 15:0 stay 0.
- R4: When `load_inc` is high at a rising edge, all 34 increment register bits are loaded from `din[33:0]`.
- R5: After a strobe load, streamed words leave increment register bits 15:0 unchanged.
- R6: On a strobe cycle the amplitude is not updated. Results derived from that word use the amplitude held from the previous streamed word.
- R7: At each edge after the increment update, the accumulator adds the increment modulo 2^34. Call the rising edges after reset release 0, 1, 2, and so on. The phase for the word sampled at edge n is the sum of the increment register values after edges 0..n. Bits 33:18 of that phase select the angle, in units of 1/65536 turn.
- R8: The result for the word sampled at edge n appears on the outputs after edge n+30, which is 31 register stages.
- R9: `cos_out` lies within 4 LSB of A·32767·cos(θ)/65536 and `sin_out` lies within 4 LSB of A·32767·sin(θ)/65536. Here A is the unsigned amplitude and θ is the angle from R7.
- R10: `out_valid` is 0 after edges 0..29 and 1 after edge 30 and every later edge, until the next reset.
- R11: Neither output ever takes the value -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 34 | Amplitude [33:18] and streamed step [17:0], or a full increment when loading |
| load_inc | input | 1 | Loads all 34 increment bits from `din` |
| cos_out | output | 16 | Scaled cosine, two's complement |
| sin_out | output | 16 | Scaled sine, two's complement |
| out_valid | output | 1 | High once the pipeline has filled after reset |

## Verification
The hardest effect to observe from the ports is the fine part of the increment. Its low 16 bits reach the angle only through carries into accumulator bit 18, so a wrong fine value moves the output by a fraction of an LSB per cycle. The stimulus therefore loads a fine-only increment and then streams words with a tiny coarse step for hundreds of cycles. Over that run the carry drift grows to hundreds of LSB in the sine output. The strobe word is also given upper bits that differ from the held amplitude, so taking the amplitude from that word would collapse the output. Random words, with occasional strobes and a fixed seed, cover the remaining combinations.

// File: rtl/nco_am_stream.sv
module nco_am_stream #(
  parameter int AMP_W   = 16,
  parameter int STEP_W  = 18,
  parameter int OUT_W   = 16,
  parameter int GUARD   = 4,
  parameter int ITER    = 16,
  parameter int LATENCY = 31
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [AMP_W+STEP_W-1:0]   din,
  input  logic                      load_inc,
  output logic signed [OUT_W-1:0]   cos_out,
  output logic signed [OUT_W-1:0]   sin_out,
  output logic                      out_valid
);
  localparam int WORD_W = AMP_W + STEP_W;
  localparam int FINE_W = WORD_W - STEP_W;
  localparam int XW     = OUT_W + GUARD + 2;
  localparam int ZW     = OUT_W + GUARD;
  localparam int PW     = OUT_W + AMP_W + 1;
  localparam int CORE   = ITER + 5;
  localparam int PAD    = LATENCY - CORE;
  localparam int CW     = $clog2(LATENCY + 1);
  localparam longint FS = ((longint'(1) << (OUT_W - 1)) - 1) << GUARD;
  localparam logic signed [XW-1:0] X_INIT = XW'((FS * 607253 + 500000) / 1000000);
  localparam logic signed [XW-1:0] HALF_G = XW'(1 << (GUARD - 1));
  localparam logic signed [XW-1:0] TOP    = XW'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [PW-1:0] HALF_A = PW'(1) << (AMP_W - 1);

  function automatic logic signed [ZW-1:0] atan_step(input int i);
    longint v;
    case (i)
      0: v = 131072;  1: v = 77376;  2: v = 40884;  3: v = 20753;
      4: v = 10417;   5: v = 5213;   6: v = 2607;   7: v = 1304;
      8: v = 652;     9: v = 326;    10: v = 163;   11: v = 81;
      12: v = 41;     13: v = 20;    14: v = 10;    15: v = 5;
      16: v = 3;      17: v = 1;     18: v = 1;
      default: v = 0;
    endcase
    return ZW'((v << ZW) >> 20);
  endfunction

  function automatic logic signed [OUT_W-1:0] trim(input logic signed [XW-1:0] v);
    logic signed [XW-1:0] t;
    t = (v + HALF_G) >>> GUARD;
    if (t > TOP) t = TOP;
    else if (t < -TOP) t = -TOP;
    return OUT_W'(t);
  endfunction

  logic [WORD_W-1:0] inc_q, acc_q;
  logic [AMP_W-1:0]  amp_q [0:ITER+3];

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q    <= '0;
      amp_q[0] <= '0;
    end else if (load_inc) begin
      inc_q <= din;
    end else begin
      inc_q    <= {din[STEP_W-1:0], inc_q[FINE_W-1:0]};
      amp_q[0] <= din[WORD_W-1 -: AMP_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_q + inc_q;
  end

  always_ff @(posedge clk) begin
    for (int i = 1; i <= ITER + 3; i++)
      amp_q[i] <= rst ? '0 : amp_q[i-1];
  end

  logic [OUT_W-1:0] ang;
  logic             flip;
  assign ang  = acc_q[WORD_W-1 -: OUT_W];
  assign flip = ang[OUT_W-1] ^ ang[OUT_W-2];

  logic signed [XW-1:0] cx [0:ITER];
  logic signed [XW-1:0] cy [0:ITER];
  logic signed [ZW-1:0] cz [0:ITER-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cx[0] <= '0;
      cy[0] <= '0;
      cz[0] <= '0;
    end else begin
      cx[0] <= flip ? -X_INIT : X_INIT;
      cy[0] <= '0;
      cz[0] <= {ang[OUT_W-2], ang[OUT_W-2:0], {GUARD{1'b0}}};
    end
  end

  for (genvar i = 0; i < ITER; i++) begin : g_rot
    localparam logic signed [ZW-1:0] ANG = atan_step(i);
    always_ff @(posedge clk) begin
      if (rst) begin
        cx[i+1] <= '0;
        cy[i+1] <= '0;
      end else if (cz[i][ZW-1]) begin
        cx[i+1] <= cx[i] + (cy[i] >>> i);
        cy[i+1] <= cy[i] - (cx[i] >>> i);
      end else begin
        cx[i+1] <= cx[i] - (cy[i] >>> i);
        cy[i+1] <= cy[i] + (cx[i] >>> i);
      end
    end
    if (i < ITER - 1) begin : g_z
      always_ff @(posedge clk) begin
        if (rst)              cz[i+1] <= '0;
        else if (cz[i][ZW-1]) cz[i+1] <= cz[i] + ANG;
        else                  cz[i+1] <= cz[i] - ANG;
      end
    end
  end

  logic signed [OUT_W-1:0] c_r, s_r;
  always_ff @(posedge clk) begin
    if (rst) begin
      c_r <= '0;
      s_r <= '0;
    end else begin
      c_r <= trim(cx[ITER]);
      s_r <= trim(cy[ITER]);
    end
  end

  logic signed [PW-1:0] pc, ps;
  assign pc = c_r * $signed({1'b0, amp_q[ITER+3]});
  assign ps = s_r * $signed({1'b0, amp_q[ITER+3]});

  logic signed [OUT_W-1:0] pipe_c [0:PAD];
  logic signed [OUT_W-1:0] pipe_s [0:PAD];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= PAD; i++) begin
        pipe_c[i] <= '0;
        pipe_s[i] <= '0;
      end
    end else begin
      pipe_c[0] <= OUT_W'((pc + HALF_A) >>> AMP_W);
      pipe_s[0] <= OUT_W'((ps + HALF_A) >>> AMP_W);
      for (int i = 1; i <= PAD; i++) begin
        pipe_c[i] <= pipe_c[i-1];
        pipe_s[i] <= pipe_s[i-1];
      end
    end
  end

  assign cos_out = pipe_c[PAD];
  assign sin_out = pipe_s[PAD];

  logic [CW-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      out_valid <= 1'b0;
    end else begin
      if (cnt != CW'(LATENCY)) cnt <= cnt + 1'b1;
      out_valid <= out_valid | (cnt == CW'(LATENCY - 1));
    end
  end
endmodule

module nco_am_stream_chk #(
  parameter int AMP_W   = 16,
  parameter int STEP_W  = 18,
  parameter int OUT_W   = 16,
  parameter int LATENCY = 31
) (
  input logic                         clk,
  input logic                         rst,
  input logic [AMP_W+STEP_W-1:0]      din,
  input logic                         load_inc,
  input logic [AMP_W+STEP_W-1:0]      inc_q,
  input logic [AMP_W-1:0]             amp_now,
  input logic [AMP_W+STEP_W-1:0]      acc_q,
  input logic signed [OUT_W-1:0]      cos_out,
  input logic signed [OUT_W-1:0]      sin_out,
  input logic                         out_valid
);
  localparam int WORD_W = AMP_W + STEP_W;
  localparam int FINE_W = WORD_W - STEP_W;
  localparam int CW     = $clog2(LATENCY + 1);
  localparam logic signed [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

  logic [CW-1:0] cc;
  always_ff @(posedge clk) begin
    if (rst) cc <= '0;
    else if (cc != CW'(LATENCY)) cc <= cc + 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && cos_out == '0 && sin_out == '0 && inc_q == '0));

  // R2
  stream_step_chk: assert property (@(posedge clk) disable iff (rst)
    !load_inc |=> inc_q[WORD_W-1:FINE_W] == $past(din[STEP_W-1:0]));

  // R2
  stream_amp_chk: assert property (@(posedge clk) disable iff (rst)
    !load_inc |=> amp_now == $past(din[WORD_W-1:STEP_W]));

  // R4
  full_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_inc |=> inc_q == $past(din));

  // R5
  fine_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !load_inc |=> $stable(inc_q[FINE_W-1:0]));

  // R6
  amp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    load_inc |=> $stable(amp_now));

  // R7
  accumulate_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> acc_q == $past(acc_q) + $past(inc_q));

  // R10
  valid_timing_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == (cc >= CW'(LATENCY)));

  // R10
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);

  // R11
  no_min_chk: assert property (@(posedge clk) disable iff (rst)
    cos_out != MINV && sin_out != MINV);
endmodule

bind nco_am_stream nco_am_stream_chk #(
  .AMP_W(AMP_W), .STEP_W(STEP_W), .OUT_W(OUT_W), .LATENCY(LATENCY)
) u_chk (
  .clk(clk), .rst(rst), .din(din), .load_inc(load_inc), .inc_q(inc_q),
  .amp_now(amp_q[0]), .acc_q(acc_q), .cos_out(cos_out), .sin_out(sin_out),
  .out_valid(out_valid)
);

// File: tb/tb_nco_am_stream.sv
`timescale 1ns/1ps
module tb_nco_am_stream;
  localparam int LAT  = 31;
  localparam int NMAX = 3200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld  = 1'b0;
  logic [33:0] din = '0;
  logic signed [15:0] cos_o, sin_o;
  logic vld;

  always #2 clk = ~clk;

  nco_am_stream dut (
    .clk(clk), .rst(rst), .din(din), .load_inc(ld),
    .cos_out(cos_o), .sin_out(sin_o), .out_valid(vld)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  logic [33:0] m_inc, m_acc;
  logic [15:0] m_amp;
  logic [33:0] ph_h [0:NMAX-1];
  logic [15:0] am_h [0:NMAX-1];
  string       tag_h [0:NMAX-1];

  task automatic check_eq(string r, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic check_near(string r, int act, real exp);
    real d;
    n_cmp++;
    d = real'(act) - exp;
    if (d > 4.0 || d < -4.0) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%f", r, act, exp);
    end
  endtask

  function automatic real exp_cos(logic [33:0] ph, logic [15:0] a);
    real th;
    th = 6.283185307179586 * real'(ph[33:18]) / 65536.0;
    return real'(a) * 32767.0 * $cos(th) / 65536.0;
  endfunction

  function automatic real exp_sin(logic [33:0] ph, logic [15:0] a);
    real th;
    th = 6.283185307179586 * real'(ph[33:18]) / 65536.0;
    return real'(a) * 32767.0 * $sin(th) / 65536.0;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    ld  = 1'b0;
    din = '0;
    repeat (3) @(negedge clk);
    check_eq("R1 valid", int'(vld), 0);
    check_eq("R1 cos", int'(cos_o), 0);
    check_eq("R1 sin", int'(sin_o), 0);
    m_inc = '0;
    m_acc = '0;
    m_amp = '0;
  endtask

  task automatic step(int e, logic [33:0] w, logic l, string tag);
    rst = 1'b0;
    din = w;
    ld  = l;
    if (l) m_inc = w;
    else begin
      m_inc = {w[17:0], m_inc[15:0]};
      m_amp = w[33:18];
    end
    m_acc = m_acc + m_inc;
    ph_h[e]  = m_acc;
    am_h[e]  = m_amp;
    tag_h[e] = tag;
    @(negedge clk);
    check_eq("R10 valid", int'(vld), (e >= LAT - 1) ? 1 : 0);
    check_eq("R11 cos min", int'(cos_o == -16'sd32768), 0);
    check_eq("R11 sin min", int'(sin_o == -16'sd32768), 0);
    if (e >= LAT - 1) begin
      int j = e - (LAT - 1);
      string t = (j == 0) ? {"R8 first ", tag_h[j]} : tag_h[j];
      check_near({t, " cos"}, int'(cos_o), exp_cos(ph_h[j], am_h[j]));
      check_near({t, " sin"}, int'(sin_o), exp_sin(ph_h[j], am_h[j]));
    end
  endtask

  initial begin
    logic [63:0] r;
    void'($urandom(32'd20240611));
    do_reset();

    // segment A: zero then coarse streamed step, fine bits untouched (R3)
    for (int e = 0; e < 200; e++) begin
      if (e < 50) step(e, {16'hFFFF, 18'h0}, 1'b0, "R2 R9 full amplitude");
      else        step(e, {16'h4000, 18'h01000}, 1'b0, "R3 R7 R9 coarse step");
    end

    // segment B: strobe load of fine bits, then long streaming run
    do_reset();
    for (int e = 0; e < 800; e++) begin
      if (e < 10)
        step(e, {16'h8000, 18'h0}, 1'b0, "R2 held amplitude");
      else if (e == 10)
        step(e, {16'h0001, 2'b00, 16'hFFFF}, 1'b1, "R4 R6 load word");
      else
        step(e, {16'h8000 + 16'(e * 37), 18'h00003}, 1'b0, "R5 R7 R9 fine drift");
    end

    // segment C: random words with occasional strobes and corner amplitudes
    do_reset();
    for (int e = 0; e < 3000; e++) begin
      logic [33:0] w;
      logic l;
      r = {$urandom(), $urandom()};
      w = r[33:0];
      l = ($urandom() % 16) == 0;
      case ($urandom() % 8)
        0: w[33:18] = 16'hFFFF;
        1: w[33:18] = 16'h0000;
        default: ;
      endcase
      step(e, w, l, l ? "R4 R6 random load" : "R2 R5 R7 R9 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule